// File: doc/BRIEF.md
# Modulo-25 Counter with Mid-Count Tap

This block is a synchronous counter that steps through the values 0 to 24 and then returns to 0. It is made of two cascaded 4-bit binary stages that share one clock. The upper stage advances only when the lower stage is full and counting is enabled. The wrap back to zero is a synchronous clear, driven by a sparse decode of two count bits: bit 4 and bit 3 together mean 24 on every reachable path.

Two single-cycle flags come out beside the 8-bit count. The terminal flag marks the value 24. The tap flag marks the value 12, halfway through the cycle. The tap uses a full decode of the low nibble, so it marks one value only and not the run 12 to 15. Under a steady enable the block gives a 25-clock period. The tap fires exactly 12 clocks before the terminal flag.

Top module: `mod25_counter`

## Requirements
- R1: While the asynchronous active-high reset is asserted, the count is 0 and both flags are low, without waiting for a clock edge.
- R2: With the count enable high and the count below 24, the count rises by exactly one at the next rising clock edge.
- R3: With the count enable low and the count not equal to 24, the count keeps its value at the clock edge.
- R4: A count of 24 is held for one whole clock period and becomes 0 at the next rising edge, whatever the level of the count enable; the clear does not act before that edge.
- R5: The terminal flag is high exactly when the count equals 24.
- R6: The tap flag is high exactly when the count equals 12; values 13, 14 and 15 leave it low.
- R7: The upper 4-bit stage advances only on an enabled edge at which the lower stage holds 15, so 15 is followed by 16 (upper nibble 1, lower nibble 0).
- R8: With the enable held high, consecutive terminal pulses are 25 clocks apart, each pulse of either flag lasts one clock, and a tap pulse comes 12 clocks before the next terminal pulse.
- R9: After reset the count never exceeds 24.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock shared by both stages |
| rst_i | input | 1 | Asynchronous reset, active high, forces the count to 0 |
| cnt_en_i | input | 1 | Count enable; when low the count holds (except at 24) |
| count_o | output | 8 | Registered count value, upper nibble from the second stage |
| wrap_o | output | 1 | Terminal flag, high while the count is 24 |
| mid_o | output | 1 | Tap flag, high while the count is 12 |

## Verification
The assertions assume the block starts from reset and receives no other way of setting the count. Under that assumption the count stays within 0 to 24, so the sparse two-bit decode is an exact test for 24. They assume no more than a clean, synchronous enable. The stimulus keeps to this by loading nothing and by driving the enable only on falling edges. It mixes random enable patterns with directed runs, and it asserts the reset only between edges.

// File: rtl/mod25_pkg.sv
package mod25_pkg;

    localparam int DEF_STAGE_W = 4;
    localparam int DEF_STAGES  = 2;

    typedef struct packed {
        logic wrap;
        logic mid;
    } mod25_flags_t;

endpackage

// File: rtl/mod25_stage.sv
module mod25_stage #(
    parameter int W = 4
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         en_p_i,
    input  logic         en_t_i,
    input  logic         clr_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [W-1:0] val;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.val = '0;
        end else if (en_p_i && en_t_i) begin
            st_d.val = st_q.val + 1'b1;
        end
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.val;

endmodule

// File: rtl/mod25_decode.sv
module mod25_decode #(
    parameter int          TAP_W   = 4,
    parameter logic [31:0] TAP_VAL = 32'd12
) (
    input  logic [1:0]       wrap_bits_i,
    input  logic [TAP_W-1:0] low_i,
    output logic             clear_o,
    output logic             mid_o
);

    localparam logic [TAP_W-1:0] TAP_MATCH = TAP_VAL[TAP_W-1:0];

    // Sparse decode: both selected bits high is the terminal state.
    assign clear_o = &wrap_bits_i;
    // Full decode of the low field so the tap marks a single value.
    assign mid_o   = (low_i == TAP_MATCH);

endmodule

// File: rtl/mod25_counter.sv
module mod25_counter #(
    parameter int STAGE_W = mod25_pkg::DEF_STAGE_W,
    parameter int STAGES  = mod25_pkg::DEF_STAGES,
    parameter int WRAP_HI = 4,
    parameter int WRAP_LO = 3,
    parameter int TAP_VAL = 12
) (
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  logic                        cnt_en_i,
    output logic [STAGE_W*STAGES-1:0]   count_o,
    output logic                        wrap_o,
    output logic                        mid_o
);

    localparam int CNT_W = STAGE_W * STAGES;

    mod25_pkg::mod25_flags_t flags;
    logic [STAGES-1:0]       trickle;
    logic                    clear;

    // Carry chain: each stage trickles on only when every lower stage is full.
    assign trickle[0] = 1'b1;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g > 0) begin : g_chain
            assign trickle[g] = trickle[g-1] &&
                                (count_o[(g-1)*STAGE_W +: STAGE_W] == {STAGE_W{1'b1}});
        end
        mod25_stage #(
            .W(STAGE_W)
        ) u_stage (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .en_p_i (cnt_en_i),
            .en_t_i (trickle[g]),
            .clr_i  (clear),
            .q_o    (count_o[g*STAGE_W +: STAGE_W])
        );
    end

    mod25_decode #(
        .TAP_W   (STAGE_W),
        .TAP_VAL (TAP_VAL)
    ) u_decode (
        .wrap_bits_i ({count_o[WRAP_HI], count_o[WRAP_LO]}),
        .low_i       (count_o[STAGE_W-1:0]),
        .clear_o     (flags.wrap),
        .mid_o       (flags.mid)
    );

    assign clear  = flags.wrap;
    assign wrap_o = flags.wrap;
    assign mid_o  = flags.mid;

endmodule

// File: rtl/mod25_checker.sv
module mod25_checker #(
    parameter int CNT_W = 8,
    parameter int LAST  = 24,
    parameter int TAP   = 12
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             cnt_en_i,
    input logic [CNT_W-1:0] count_o,
    input logic             wrap_o,
    input logic             mid_o
);

    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(LAST);
    localparam logic [CNT_W-1:0] TAP_V  = CNT_W'(TAP);

    assert_step_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (cnt_en_i && !wrap_o) |=> (count_o == $past(count_o) + 1'b1));

    assert_hold_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!cnt_en_i && !wrap_o) |=> $stable(count_o));

    assert_clear_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        wrap_o |=> (count_o == '0));

    assert_wrap_flag_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        wrap_o == (count_o == LAST_V));

    assert_mid_flag_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        mid_o == (count_o == TAP_V));

    assert_wrap_single_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        wrap_o |=> !wrap_o);

    assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        count_o <= LAST_V);

endmodule

bind mod25_counter mod25_checker #(
    .CNT_W (CNT_W),
    .LAST  (24),
    .TAP   (TAP_VAL)
) u_mod25_checker (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .cnt_en_i (cnt_en_i),
    .count_o  (count_o),
    .wrap_o   (wrap_o),
    .mid_o    (mid_o)
);

// File: tb/mod25_counter_bench.sv
module mod25_counter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SEED       = 20231;

    logic       clk = 1'b0;
    logic       rst;
    logic       cnt_en;
    logic [7:0] count;
    logic       wrap;
    logic       mid;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int exp_cnt = 0;
    bit done = 0;

    mod25_counter u_mod25_counter (
        .clk_i    (clk),
        .rst_i    (rst),
        .cnt_en_i (cnt_en),
        .count_o  (count),
        .wrap_o   (wrap),
        .mid_o    (mid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int next_cnt(input int c, input bit en);
        if (c == 24) return 0;
        if (en) return c + 1;
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    task automatic check_outputs(input string tag);
        check(int'(count) == exp_cnt, tag, int'(count), exp_cnt);
        check(wrap == (exp_cnt == 24), "R5", int'(wrap), int'(exp_cnt == 24));
        check(mid == (exp_cnt == 12), "R6", int'(mid), int'(exp_cnt == 12));
        check(count <= 8'd24, "R9", int'(count), 24);
    endtask

    task automatic tick(input bit en, input string tag);
        cnt_en = en;
        @(posedge clk);
        exp_cnt = next_cnt(exp_cnt, en);
        @(negedge clk);
        cyc++;
        check_outputs(exp_cnt == 0 ? "R4" : tag);
    endtask

    task automatic run_to(input int v);
        while (exp_cnt != v) tick(1'b1, "R2");
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL R8: watchdog expired, actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        int last_wrap;
        int last_mid;
        bit prev_wrap;
        bit prev_mid;
        void'($urandom(SEED));
        rst    = 1'b1;
        cnt_en = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state with enable high
        check(count == 8'd0, "R1", int'(count), 0);
        check(!wrap && !mid, "R1", int'({wrap, mid}), 0);
        rst = 1'b0;
        exp_cnt = 0;

        // R8: continuous enable, period and pulse spacing
        last_wrap = -1;
        last_mid  = -1;
        prev_wrap = 0;
        prev_mid  = 0;
        for (int i = 0; i < 80; i++) begin
            tick(1'b1, "R2");
            if (wrap) begin
                check(!prev_wrap, "R8", 1, 0);
                if (last_wrap >= 0) check(cyc - last_wrap == 25, "R8", cyc - last_wrap, 25);
                if (last_mid >= 0) check(cyc - last_mid == 12, "R8", cyc - last_mid, 12);
                last_wrap = cyc;
            end
            if (mid) begin
                check(!prev_mid, "R8", 1, 0);
                last_mid = cyc;
            end
            prev_wrap = wrap;
            prev_mid  = mid;
        end
        check(last_wrap > 0 && last_mid > 0, "R8", last_wrap, 1);

        // R6: values 13..15 leave the tap low, R3 hold at 12
        run_to(12);
        for (int i = 0; i < 3; i++) tick(1'b0, "R3");
        tick(1'b1, "R6");
        tick(1'b1, "R6");
        tick(1'b1, "R6");
        // R7: carry into the upper stage, with a hold at 15 first
        tick(1'b0, "R7");
        check(count == 8'd15, "R7", int'(count), 15);
        tick(1'b1, "R7");
        check(count == 8'h10, "R7", int'(count), 16);

        // R4: 24 clears even with enable low, held a full period first
        run_to(24);
        check(count == 8'd24 && wrap, "R4", int'(count), 24);
        tick(1'b0, "R4");
        check(count == 8'd0, "R4", int'(count), 0);
        tick(1'b0, "R3");

        // R1: asynchronous reset between edges
        run_to(7);
        #(CLK_PERIOD/4);
        rst = 1'b1;
        #1;
        check(count == 8'd0, "R1", int'(count), 0);
        @(negedge clk);
        rst = 1'b0;
        exp_cnt = 0;
        check_outputs("R1");

        // Random enable patterns
        for (int i = 0; i < 3000; i++) begin
            bit en;
            en = ($urandom % 4) != 0;
            tick(en, en ? "R2" : "R3");
        end

        finish_run();
    end

endmodule